// File: doc/BRIEF.md
# Merging Committed Store Buffer

This block sits between the point where stores retire and the data cache. Retired stores are collected in a small fully associative array whose entries each hold one whole cache line, together with a byte-valid mask. A store that lands in a line that is already resident is folded into that entry, so many narrow stores turn into a single full-line write towards the cache. That write leaves over a valid/ready port.

Two store writes can arrive in each cycle. Each one carries a slot-sized chunk of data, a byte mask and a slot index within the line. A store can instead be a zeroing request, which clears a whole line at once. Lines leave the buffer for one of three reasons. The first is that an entry has stayed resident too long. The second is that a flush has been requested, for example ahead of a fence or an atomic operation. The third is that more entries are in use than a programmable threshold allows. Load lookups can query the buffer at any time. A lookup returns the resident bytes for a line address and a mask of which of those bytes hold data.

Top module: `store_merge_buf`

## Requirements
- R1: After reset, `dc_valid` and `fwd_hit` are low, and both `flush_done` and `wr_ready` are high.
- R2: A store to a resident line writes the bytes its mask selects and keeps every other byte of the entry. The entry's byte mask becomes the OR of the old mask and the new one. Slot index s places data byte k at line byte s*SLOT_BYTES+k.
- R3: When both write ports carry the same line in one cycle, port 1 is treated as the younger store: where the two masks overlap, the bytes of port 1 win.
- R4: Two stores in one cycle to two different non-resident lines each get an entry of their own.
- R5: A zeroing request sets all line bytes to zero and all mask bits to one. A port 1 store to the same line in the same cycle is then laid over the zeroed line.
- R6: While more than EVICT_AT entries are valid, one line is evicted. The victim is the lowest-index valid entry whose recently-used bit is clear. A write sets the used bit of the entry it writes. If that leaves every valid entry marked as used, only the entries touched in that cycle stay marked.
- R7: A flush request evicts all entries. `flush_done` goes low in the cycle after the request and goes high again once the buffer and the output register are both empty.
- R8: An entry is evicted by age 2^AGE_W+1 cycles after it was allocated, and not earlier. This happens even when no other eviction cause is present.
- R9: While `dc_ready` is low, `dc_valid`, `dc_line` and `dc_data` hold their values. After a handshake, `dc_valid` is low for at least one cycle.
- R10: `wr_ready` is high only while at least two entries are free. Stores presented while it is low are dropped and never become visible.
- R11: A lookup on `fwd_line` answers one cycle later. On a hit it returns the entry's data and mask with `fwd_hit` high. On a miss, `fwd_hit` is low and both data and mask read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr0_valid | input | 1 | Store on port 0 (older) |
| wr0_line | input | LINE_AW | Line address of port 0 |
| wr0_slot | input | log2(LINE_BYTES/SLOT_BYTES) | Slot index within the line |
| wr0_data | input | SLOT_BYTES*8 | Store data |
| wr0_mask | input | SLOT_BYTES | Byte enables |
| wr0_zero | input | 1 | Zero the whole line |
| wr1_valid | input | 1 | Store on port 1 (younger) |
| wr1_line | input | LINE_AW | Line address of port 1 |
| wr1_slot | input | log2(LINE_BYTES/SLOT_BYTES) | Slot index within the line |
| wr1_data | input | SLOT_BYTES*8 | Store data |
| wr1_mask | input | SLOT_BYTES | Byte enables |
| wr1_zero | input | 1 | Zero the whole line |
| wr_ready | output | 1 | Both ports may write this cycle |
| flush_req | input | 1 | Drain request pulse |
| flush_done | output | 1 | Buffer and output register empty, no drain pending |
| fwd_line | input | LINE_AW | Lookup line address |
| fwd_hit | output | 1 | Lookup hit (registered) |
| fwd_data | output | LINE_BYTES*8 | Resident line bytes |
| fwd_mask | output | LINE_BYTES | Resident byte mask |
| dc_valid | output | 1 | Line write to cache pending |
| dc_ready | input | 1 | Cache accepts the line |
| dc_line | output | LINE_AW | Evicted line address |
| dc_data | output | LINE_BYTES*8 | Evicted line bytes |
| dc_mask | output | LINE_BYTES | Evicted byte mask |

## Verification
The bench builds the block with 4 entries, 16-byte lines made of four 4-byte slots, 8-bit line addresses, an eviction threshold of 2 and an age limit of 2^7 cycles. With these values every slot index and every non-empty 4-bit mask can be swept. Filling three entries is enough to trigger a threshold eviction, which puts the choice of victim within reach. Filling one more entry with the cache port stalled drops `wr_ready`. The age timeout fires after about 130 cycles, so it can be watched directly. The expected contents of each line come from a byte-level model in the bench, which applies port 0 first and port 1 second.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    EVT_IDLE  = 2'd0,
    EVT_AGE   = 2'd1,
    EVT_DRAIN = 2'd2,
    EVT_FULL  = 2'd3
  } evict_why_t;
endpackage

// File: rtl/smb_lane.sv
module smb_lane #(
  parameter int LINE_BYTES = 64,
  parameter int SLOT_BYTES = 16
) (
  input  logic [$clog2(LINE_BYTES/SLOT_BYTES)-1:0] slot,
  input  logic [SLOT_BYTES*8-1:0]                  data,
  input  logic [SLOT_BYTES-1:0]                    mask,
  input  logic                                     zero,
  output logic [LINE_BYTES*8-1:0]                  wide_data,
  output logic [LINE_BYTES-1:0]                    wide_mask
);
  localparam int NSLOT = LINE_BYTES / SLOT_BYTES;
  localparam int OW    = $clog2(NSLOT);
  localparam int SW    = SLOT_BYTES * 8;

  always_comb begin
    wide_data = '0;
    wide_mask = '0;
    if (zero) begin
      wide_mask = '1;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot == OW'(s)) begin
          wide_data[s*SW +: SW]         = data;
          wide_mask[s*SLOT_BYTES +: SLOT_BYTES] = mask;
        end
      end
    end
  end
endmodule

// File: rtl/smb_lookup.sv
module smb_lookup #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 34
) (
  input  logic [ENTRIES-1:0]         live,
  input  logic [TAG_W-1:0]           tags [ENTRIES],
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [$clog2(ENTRIES)-1:0] idx
);
  localparam int IW = $clog2(ENTRIES);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IW'(i);
    end
    hit = |match;
  end
endmodule

// File: rtl/smb_victim.sv
module smb_victim
  import smb_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int AGE_W    = 20,
  parameter int EVICT_AT = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ENTRIES-1:0]         vld,
  input  logic [ENTRIES-1:0]         alloc,
  input  logic [ENTRIES-1:0]         touch,
  input  logic [ENTRIES-1:0]         launch_vec,
  input  logic                       flush_pend,
  input  logic                       out_busy,
  output evict_why_t                 why,
  output logic [$clog2(ENTRIES)-1:0] age_idx,
  output logic [$clog2(ENTRIES)-1:0] plru_idx
);
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = $clog2(ENTRIES + 1);

  logic [AGE_W:0]      age [ENTRIES];
  logic [ENTRIES-1:0]  used, used_raw, vld_nx, stale;
  logic [IW-1:0]       cold_idx, low_idx;
  logic                any_cold;
  logic [CW-1:0]       occ;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst || alloc[i])                 age[i] <= '0;
      else if (vld[i] && !age[i][AGE_W])   age[i] <= age[i] + 1'b1;
    end
  end

  always_comb begin
    used_raw = (used & ~launch_vec) | touch;
    vld_nx   = (vld & ~launch_vec) | alloc;
  end

  always_ff @(posedge clk) begin
    if (rst)                                  used <= '0;
    else if ((used_raw & vld_nx) == vld_nx)   used <= touch;
    else                                      used <= used_raw & vld_nx;
  end

  always_comb begin
    age_idx  = '0;
    cold_idx = '0;
    low_idx  = '0;
    any_cold = 1'b0;
    occ      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      stale[i] = vld[i] && age[i][AGE_W];
      if (stale[i]) age_idx = IW'(i);
      if (vld[i] && !used[i]) begin
        cold_idx = IW'(i);
        any_cold = 1'b1;
      end
      if (vld[i]) low_idx = IW'(i);
      occ = occ + CW'(vld[i]);
    end
    plru_idx = any_cold ? cold_idx : low_idx;
  end

  always_comb begin
    if (out_busy)                       why = EVT_IDLE;
    else if (|stale)                    why = EVT_AGE;
    else if (flush_pend && |vld)        why = EVT_DRAIN;
    else if (int'(occ) > EVICT_AT)      why = EVT_FULL;
    else                                why = EVT_IDLE;
  end
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
  import smb_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int LINE_BYTES = 64,
  parameter int SLOT_BYTES = 16,
  parameter int LINE_AW    = 34,
  parameter int AGE_W      = 20,
  parameter int EVICT_AT   = 12
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr0_valid,
  input  logic [LINE_AW-1:0]                       wr0_line,
  input  logic [$clog2(LINE_BYTES/SLOT_BYTES)-1:0] wr0_slot,
  input  logic [SLOT_BYTES*8-1:0]                  wr0_data,
  input  logic [SLOT_BYTES-1:0]                    wr0_mask,
  input  logic                                     wr0_zero,
  input  logic                                     wr1_valid,
  input  logic [LINE_AW-1:0]                       wr1_line,
  input  logic [$clog2(LINE_BYTES/SLOT_BYTES)-1:0] wr1_slot,
  input  logic [SLOT_BYTES*8-1:0]                  wr1_data,
  input  logic [SLOT_BYTES-1:0]                    wr1_mask,
  input  logic                                     wr1_zero,
  output logic                                     wr_ready,
  input  logic                                     flush_req,
  output logic                                     flush_done,
  input  logic [LINE_AW-1:0]                       fwd_line,
  output logic                                     fwd_hit,
  output logic [LINE_BYTES*8-1:0]                  fwd_data,
  output logic [LINE_BYTES-1:0]                    fwd_mask,
  output logic                                     dc_valid,
  input  logic                                     dc_ready,
  output logic [LINE_AW-1:0]                       dc_line,
  output logic [LINE_BYTES*8-1:0]                  dc_data,
  output logic [LINE_BYTES-1:0]                    dc_mask
);
  localparam int LW = LINE_BYTES * 8;
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = $clog2(ENTRIES + 1);

  // entry storage
  logic [ENTRIES-1:0]    vld;
  logic [LINE_AW-1:0]    tag [ENTRIES];
  logic [LW-1:0]         dat [ENTRIES];
  logic [LINE_BYTES-1:0] msk [ENTRIES];
  logic                  flush_pend;

  // eviction selection
  evict_why_t         why;
  logic [IW-1:0]      age_idx, plru_idx, launch_idx;
  logic               launch_en;
  logic [ENTRIES-1:0] launch_vec, live;

  always_comb begin
    launch_en  = (why != EVT_IDLE);
    launch_idx = (why == EVT_AGE) ? age_idx : plru_idx;
    launch_vec = '0;
    if (launch_en) launch_vec[launch_idx] = 1'b1;
    live = vld & ~launch_vec;
  end

  // free entries and write admission
  logic [CW-1:0] nfree;
  logic [IW-1:0] free_a, free_b;
  logic          take0, take1;

  always_comb begin
    int seen;
    seen   = 0;
    nfree  = '0;
    free_a = '0;
    free_b = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld[i]) begin
        if (seen == 0)      free_a = IW'(i);
        else if (seen == 1) free_b = IW'(i);
        seen  = seen + 1;
        nfree = nfree + 1'b1;
      end
    end
    wr_ready = (nfree >= CW'(2));
    take0    = wr0_valid && wr_ready;
    take1    = wr1_valid && wr_ready;
  end

  // associative matches
  logic          hit0, hit1, fhit;
  logic [IW-1:0] hidx0, hidx1, fidx;

  smb_lookup #(.ENTRIES(ENTRIES), .TAG_W(LINE_AW)) lk0_i (
    .live(live), .tags(tag), .key(wr0_line), .hit(hit0), .idx(hidx0));
  smb_lookup #(.ENTRIES(ENTRIES), .TAG_W(LINE_AW)) lk1_i (
    .live(live), .tags(tag), .key(wr1_line), .hit(hit1), .idx(hidx1));
  smb_lookup #(.ENTRIES(ENTRIES), .TAG_W(LINE_AW)) lkf_i (
    .live(vld), .tags(tag), .key(fwd_line), .hit(fhit), .idx(fidx));

  // target entry of each port
  logic               same;
  logic [IW-1:0]      tgt0, tgt1;
  logic [ENTRIES-1:0] touch, alloc;

  always_comb begin
    same = take0 && take1 && (wr0_line == wr1_line);
    tgt0 = hit0 ? hidx0 : free_a;
    if (hit1)                 tgt1 = hidx1;
    else if (same)            tgt1 = tgt0;
    else if (take0 && !hit0)  tgt1 = free_b;
    else                      tgt1 = free_a;
    touch = '0;
    if (take0) touch[tgt0] = 1'b1;
    if (take1) touch[tgt1] = 1'b1;
    alloc = touch & ~vld;
  end

  // widen each store to a full line
  logic [LW-1:0]         wd0, wd1;
  logic [LINE_BYTES-1:0] wm0, wm1;

  smb_lane #(.LINE_BYTES(LINE_BYTES), .SLOT_BYTES(SLOT_BYTES)) lane0_i (
    .slot(wr0_slot), .data(wr0_data), .mask(wr0_mask), .zero(wr0_zero),
    .wide_data(wd0), .wide_mask(wm0));
  smb_lane #(.LINE_BYTES(LINE_BYTES), .SLOT_BYTES(SLOT_BYTES)) lane1_i (
    .slot(wr1_slot), .data(wr1_data), .mask(wr1_mask), .zero(wr1_zero),
    .wide_data(wd1), .wide_mask(wm1));

  // byte merge: port 0 first, port 1 on top
  logic [LW-1:0]         nd [ENTRIES];
  logic [LINE_BYTES-1:0] nm [ENTRIES];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic h0, h1;
      h0    = take0 && (tgt0 == IW'(i));
      h1    = take1 && (tgt1 == IW'(i));
      nd[i] = vld[i] ? dat[i] : '0;
      nm[i] = vld[i] ? msk[i] : '0;
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (h0 && wm0[b]) nd[i][b*8 +: 8] = wd0[b*8 +: 8];
        if (h1 && wm1[b]) nd[i][b*8 +: 8] = wd1[b*8 +: 8];
      end
      if (h0) nm[i] = nm[i] | wm0;
      if (h1) nm[i] = nm[i] | wm1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= (vld & ~launch_vec) | touch;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (touch[i]) begin
        tag[i] <= (take0 && tgt0 == IW'(i)) ? wr0_line : wr1_line;
        dat[i] <= nd[i];
        msk[i] <= nm[i];
      end
    end
  end

  smb_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W), .EVICT_AT(EVICT_AT)) vic_i (
    .clk(clk), .rst(rst), .vld(vld), .alloc(alloc), .touch(touch),
    .launch_vec(launch_vec), .flush_pend(flush_pend), .out_busy(dc_valid),
    .why(why), .age_idx(age_idx), .plru_idx(plru_idx));

  // cache write port
  always_ff @(posedge clk) begin
    if (rst) begin
      dc_valid <= 1'b0;
      dc_line  <= '0;
      dc_data  <= '0;
      dc_mask  <= '0;
    end else if (dc_valid) begin
      if (dc_ready) dc_valid <= 1'b0;
    end else if (launch_en) begin
      dc_valid <= 1'b1;
      dc_line  <= tag[launch_idx];
      dc_data  <= dat[launch_idx];
      dc_mask  <= msk[launch_idx];
    end
  end

  // drain control
  always_ff @(posedge clk) begin
    if (rst)                          flush_pend <= 1'b0;
    else if (flush_req)               flush_pend <= 1'b1;
    else if (vld == '0 && !dc_valid)  flush_pend <= 1'b0;
  end

  assign flush_done = !flush_pend && (vld == '0) && !dc_valid;

  // load forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
      fwd_mask <= '0;
    end else begin
      fwd_hit  <= fhit;
      fwd_data <= fhit ? dat[fidx] : '0;
      fwd_mask <= fhit ? msk[fidx] : '0;
    end
  end
endmodule

// File: rtl/smb_chk.sv
module smb_chk #(
  parameter int LINE_AW    = 34,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    dc_valid,
  input logic                    dc_ready,
  input logic [LINE_AW-1:0]      dc_line,
  input logic [LINE_BYTES*8-1:0] dc_data,
  input logic                    flush_req,
  input logic                    flush_done,
  input logic                    wr_ready,
  input logic                    fwd_hit,
  input logic [LINE_BYTES-1:0]   fwd_mask
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dc_valid && !dc_ready |=> dc_valid && $stable(dc_line) && $stable(dc_data));

  // R9
  out_gap_chk: assert property (@(posedge clk) disable iff (rst)
    dc_valid && dc_ready |=> !dc_valid);

  // R7
  drain_ack_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_done);

  // R10
  busy_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |-> !flush_done);

  // R11
  miss_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd_hit |-> fwd_mask == '0);
endmodule

bind store_merge_buf smb_chk #(.LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rst(rst), .dc_valid(dc_valid), .dc_ready(dc_ready),
  .dc_line(dc_line), .dc_data(dc_data), .flush_req(flush_req),
  .flush_done(flush_done), .wr_ready(wr_ready), .fwd_hit(fwd_hit),
  .fwd_mask(fwd_mask));

// File: tb/store_merge_buf_tb_top.sv
module store_merge_buf_tb_top;
  localparam int E  = 4;
  localparam int LB = 16;
  localparam int SB = 4;
  localparam int AW = 8;
  localparam int TW = 7;
  localparam int TH = 2;
  localparam int LW = LB * 8;
  localparam int SW = SB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr0_valid = 1'b0, wr1_valid = 1'b0, wr0_zero = 1'b0, wr1_zero = 1'b0;
  logic [AW-1:0] wr0_line = '0, wr1_line = '0, fwd_line = '0;
  logic [1:0] wr0_slot = '0, wr1_slot = '0;
  logic [SW-1:0] wr0_data = '0, wr1_data = '0;
  logic [SB-1:0] wr0_mask = '0, wr1_mask = '0;
  logic flush_req = 1'b0, dc_ready = 1'b1;
  logic wr_ready, flush_done, fwd_hit, dc_valid;
  logic [LW-1:0] fwd_data, dc_data;
  logic [LB-1:0] fwd_mask, dc_mask;
  logic [AW-1:0] dc_line;

  always #4 clk = ~clk;

  store_merge_buf #(.ENTRIES(E), .LINE_BYTES(LB), .SLOT_BYTES(SB), .LINE_AW(AW),
                    .AGE_W(TW), .EVICT_AT(TH)) dut_i (
    .clk(clk), .rst(rst),
    .wr0_valid(wr0_valid), .wr0_line(wr0_line), .wr0_slot(wr0_slot),
    .wr0_data(wr0_data), .wr0_mask(wr0_mask), .wr0_zero(wr0_zero),
    .wr1_valid(wr1_valid), .wr1_line(wr1_line), .wr1_slot(wr1_slot),
    .wr1_data(wr1_data), .wr1_mask(wr1_mask), .wr1_zero(wr1_zero),
    .wr_ready(wr_ready), .flush_req(flush_req), .flush_done(flush_done),
    .fwd_line(fwd_line), .fwd_hit(fwd_hit), .fwd_data(fwd_data), .fwd_mask(fwd_mask),
    .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_line(dc_line),
    .dc_data(dc_data), .dc_mask(dc_mask));

  int checks = 0;
  int errors = 0;
  int on = 0;
  int ptr = 0;
  logic [7:0]    md [16][16];
  logic          mm [16][16];
  logic [AW-1:0] ol [64];
  logic [LW-1:0] od [64];
  logic [LB-1:0] om [64];

  always @(negedge clk) begin
    if (!rst && dc_valid && dc_ready && on < 64) begin
      ol[on] = dc_line;
      od[on] = dc_data;
      om[on] = dc_mask;
      on = on + 1;
    end
  end

  task automatic ck(input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(input int line, input int idx, input int seed);
    return 8'(line * 37 + idx * 11 + seed * 5 + 1);
  endfunction

  function automatic logic [LW-1:0] ed(input int line);
    logic [LW-1:0] v = '0;
    for (int b = 0; b < LB; b++) v[b*8 +: 8] = md[line][b];
    return v;
  endfunction

  function automatic logic [LB-1:0] em(input int line);
    logic [LB-1:0] v = '0;
    for (int b = 0; b < LB; b++) v[b] = mm[line][b];
    return v;
  endfunction

  task automatic drive0(input int line, input int slot, input logic [3:0] mk,
                        input int seed, input logic z);
    wr0_valid = 1'b1; wr0_line = AW'(line); wr0_slot = 2'(slot);
    wr0_mask = mk; wr0_zero = z;
    for (int k = 0; k < SB; k++) wr0_data[k*8 +: 8] = bv(line, slot * SB + k, seed);
  endtask

  task automatic drive1(input int line, input int slot, input logic [3:0] mk,
                        input int seed, input logic z);
    wr1_valid = 1'b1; wr1_line = AW'(line); wr1_slot = 2'(slot);
    wr1_mask = mk; wr1_zero = z;
    for (int k = 0; k < SB; k++) wr1_data[k*8 +: 8] = bv(line, slot * SB + k, seed);
  endtask

  task automatic app(input int line, input int slot, input logic [3:0] mk,
                     input logic [SW-1:0] d, input logic z);
    if (z) begin
      for (int b = 0; b < LB; b++) begin md[line][b] = 8'h00; mm[line][b] = 1'b1; end
    end else begin
      for (int k = 0; k < SB; k++)
        if (mk[k]) begin md[line][slot*SB+k] = d[k*8 +: 8]; mm[line][slot*SB+k] = 1'b1; end
    end
  endtask

  task automatic pulse();
    if (wr_ready) begin
      if (wr0_valid) app(int'(wr0_line), int'(wr0_slot), wr0_mask, wr0_data, wr0_zero);
      if (wr1_valid) app(int'(wr1_line), int'(wr1_slot), wr1_mask, wr1_data, wr1_zero);
    end
    @(posedge clk); @(negedge clk);
    wr0_valid = 1'b0; wr1_valid = 1'b0; wr0_zero = 1'b0; wr1_zero = 1'b0;
  endtask

  task automatic look(input string r, input int line, input logic exp_hit);
    fwd_line = AW'(line);
    @(posedge clk); @(negedge clk);
    ck({r, " fwd_hit"}, LW'(fwd_hit), LW'(exp_hit));
    ck({r, " fwd_data"}, fwd_data, exp_hit ? ed(line) : '0);
    ck({r, " fwd_mask"}, LW'(fwd_mask), exp_hit ? LW'(em(line)) : '0);
  endtask

  task automatic clear_line(input int line);
    for (int b = 0; b < LB; b++) begin md[line][b] = 8'h00; mm[line][b] = 1'b0; end
  endtask

  task automatic drain();
    int held = 0;
    for (int l = 0; l < 16; l++) if (em(l) != '0) held++;
    dc_ready = 1'b1;
    flush_req = 1'b1;
    @(posedge clk); @(negedge clk);
    flush_req = 1'b0;
    for (int w = 0; w < 100 && !flush_done; w++) @(negedge clk);
    ck("R7 flush_done", LW'(flush_done), LW'(1));
    ck("R7 drained count", LW'(on - ptr), LW'(held));
    for (int j = ptr; j < on; j++) begin
      ck("R7 drained data", od[j], ed(int'(ol[j])));
      ck("R7 drained mask", LW'(om[j]), LW'(em(int'(ol[j]))));
      clear_line(int'(ol[j]));
    end
    ptr = on;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 16; l++) clear_line(l);
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1
    ck("R1 dc_valid", LW'(dc_valid), LW'(0));
    ck("R1 flush_done", LW'(flush_done), LW'(1));
    ck("R1 wr_ready", LW'(wr_ready), LW'(1));
    ck("R1 fwd_hit", LW'(fwd_hit), LW'(0));

    // R2 merge sweep over every non-empty mask and every slot, R11 lookups
    for (int mk = 1; mk < 16; mk++) begin
      drive0(3, mk % 4, 4'(mk), mk, 1'b0);
      pulse();
      look("R2", 3, 1'b1);
    end
    look("R11 miss", 9, 1'b0);
    drain();

    // R3 same line on both ports, overlapping masks
    for (int v = 0; v < 4; v++) begin
      drive0(5, v, 4'hF, 10 + v, 1'b0);
      drive1(5, v, 4'(v * 5 + 2), 20 + v, 1'b0);
      pulse();
      look("R3", 5, 1'b1);
    end
    drain();

    // R4 two new lines in one cycle
    drive0(6, 1, 4'h9, 3, 1'b0);
    drive1(7, 2, 4'h6, 4, 1'b0);
    pulse();
    look("R4 port0 line", 6, 1'b1);
    look("R4 port1 line", 7, 1'b1);
    drain();

    // R5 zeroing, then younger store laid over it
    drive0(2, 0, 4'h5, 7, 1'b0);
    pulse();
    drive0(2, 0, 4'h0, 0, 1'b1);
    drive1(2, 3, 4'h3, 8, 1'b0);
    pulse();
    look("R5", 2, 1'b1);
    drain();

    // R6 threshold eviction picks the entry not recently written
    drive0(10, 0, 4'hF, 1, 1'b0); pulse();
    drive0(11, 1, 4'hF, 2, 1'b0); pulse();
    drive0(10, 2, 4'h3, 3, 1'b0); pulse();
    drive0(12, 3, 4'hC, 4, 1'b0); pulse();
    @(negedge clk); @(negedge clk);
    ck("R6 one eviction", LW'(on - ptr), LW'(1));
    ck("R6 victim line", LW'(ol[ptr]), LW'(11));
    ck("R6 victim data", od[ptr], ed(11));
    clear_line(11);
    ptr = on;
    look("R6 victim gone", 11, 1'b0);
    look("R6 kept", 10, 1'b1);
    drain();

    // R10 and R9 with the cache port stalled
    dc_ready = 1'b0;
    drive0(1, 0, 4'hF, 5, 1'b0); pulse();
    drive0(4, 1, 4'hF, 6, 1'b0); pulse();
    drive0(13, 2, 4'hF, 7, 1'b0); pulse();
    @(negedge clk); @(negedge clk);
    ck("R9 stalled valid", LW'(dc_valid), LW'(1));
    ck("R9 stalled line", LW'(dc_line), LW'(1));
    drive0(14, 3, 4'hF, 8, 1'b0); pulse();
    ck("R10 wr_ready low", LW'(wr_ready), LW'(0));
    drive0(15, 0, 4'hF, 9, 1'b0); pulse();
    look("R10 dropped store", 15, 1'b0);
    ck("R9 held line", LW'(dc_line), LW'(1));
    ck("R9 held data", dc_data, ed(1));
    drain();

    // R8 age eviction with no other cause
    drive0(6, 2, 4'hA, 11, 1'b0); pulse();
    repeat (120) @(negedge clk);
    ck("R8 not early", LW'(on - ptr), LW'(0));
    for (int w = 0; w < 30 && on == ptr; w++) @(negedge clk);
    ck("R8 evicted", LW'(on - ptr), LW'(1));
    ck("R8 line", LW'(ol[ptr]), LW'(6));
    ck("R8 data", od[ptr], ed(6));
    clear_line(6);
    ptr = on;
    @(negedge clk);
    ck("R8 empty after", LW'(flush_done), LW'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule